// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block lets clocked logic use an external asynchronous static RAM of 128K bytes. A requester presents one transfer at a time on a valid/ready handshake: a 17-bit word address, a write flag and a write byte. The controller runs the RAM's pin-level protocol and, for reads, returns the byte with a one-clock response pulse.

The block drives these RAM signals:

- an address bus
- two chip selects, one active-low and one active-high
- an active-low output enable
- an active-low write enable
- the byte bus, split into an output value, an output-enable and a sampled input

Every phase of a bus cycle lasts a parameterised number of clocks. These counts are chosen by rounding the RAM's nanosecond minimums up to whole periods of the system clock.

A write runs four phases:

- **Setup:** the RAM is selected.
- **Turnaround:** write enable is low and the bus is not driven, giving the RAM time to release it.
- **Data:** write enable is low and the byte is driven.
- **Hold:** write enable is high again, while the byte, address and selects stay put.

A read runs two phases:

- **Setup:** the RAM is selected.
- **Access:** output enable is low, and the byte is captured on the final clock of this phase.

Between any two transfers the RAM is deselected for at least one clock.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst_n` is low, `req_ready` is low, both chip selects are inactive, `mem_we_n` and `mem_oe_n` are high and `mem_dq_oe` is low; a request held valid during reset is not taken, and once reset is released `req_ready` goes high with the RAM still deselected.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the next clock until the controller is idle again.
- R3: The first SETUP_CYC clocks after acceptance select the RAM (`mem_cs_n`=0, `mem_cs`=1) with `mem_we_n`=1, `mem_oe_n`=1 and the data driver off.
- R4: For a write, the first TURN_CYC clocks with `mem_we_n`=0 keep `mem_dq_oe`=0.
- R5: For a write, the byte is driven with `mem_dq_oe`=1 for DATA_CYC clocks before `mem_we_n` rises. For HOLD_CYC clocks after the rise, the byte stays driven, the RAM stays selected and the address is unchanged.
- R6: For a read, `mem_oe_n` is low for ACCESS_CYC clocks after setup, with `mem_we_n`=1 and the driver off.
- R7: The read byte is sampled from `mem_dq_i` on the last access clock. `rsp_valid` is high for exactly one clock, the clock after that capture, with the byte on `rsp_rdata`.
- R8: After each transfer, the RAM is deselected with all strobes inactive and the driver off for at least one clock before the next setup. A write produces no `rsp_valid`. A request held valid back-to-back is taken in the first idle clock.
- R9: `mem_addr` carries the accepted 17-bit address and stays stable while the RAM is selected.
- R10: `mem_we_n` and `mem_oe_n` are never low together, and `mem_dq_oe` is never high while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 17 | RAM address bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Byte driven onto the RAM bus |
| mem_dq_oe | output | 1 | Enable of the byte driver |
| mem_dq_i | input | 8 | Byte sampled from the RAM bus |

## Verification
Writes and reads are applied at address extremes (all zeros, all ones) and at mixed patterns, with data bytes 00, FF, A5, 5A and others. Every clock of every phase is compared against the expected strobe vector, so a phase that is too long, too short or out of order shows up as a mismatch at a specific clock.

The RAM model returns a junk byte whenever output enable is high. A capture taken at the wrong clock therefore returns the wrong byte. The model also stores whatever is on the bus at the rising edge of write enable, so a byte released too early is caught when it is read back.

Back-to-back transfers with valid held high separate the idle gap and the acceptance timing from single, isolated requests. Overwriting an address and reading it again shows that the latest write wins.

// File: rtl/asram_pkg.sv
package asram_pkg;

    // Width of the per-phase clock counter; each phase length must fit in it.
    localparam int PH_CNT_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_WTURN,
        PH_WDATA,
        PH_WHOLD,
        PH_RACC
    } phase_e;

    // Sequencer state; the strobe bits are registered so pins never glitch.
    typedef struct packed {
        phase_e                ph;
        logic [PH_CNT_W-1:0]   cnt;
        logic                  wr;
        logic                  cs_act;
        logic                  we_act;
        logic                  oe_act;
        logic                  drv;
    } seq_t;

endpackage

// File: rtl/asram_phase_len.sv
module asram_phase_len
    import asram_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int TURN_CYC   = 2,
    parameter int DATA_CYC   = 4,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 7
) (
    input  phase_e              ph,
    output logic [PH_CNT_W-1:0] len_m1
);

    localparam logic [PH_CNT_W-1:0] SETUP_M1  = PH_CNT_W'(SETUP_CYC - 1);
    localparam logic [PH_CNT_W-1:0] TURN_M1   = PH_CNT_W'(TURN_CYC - 1);
    localparam logic [PH_CNT_W-1:0] DATA_M1   = PH_CNT_W'(DATA_CYC - 1);
    localparam logic [PH_CNT_W-1:0] HOLD_M1   = PH_CNT_W'(HOLD_CYC - 1);
    localparam logic [PH_CNT_W-1:0] ACCESS_M1 = PH_CNT_W'(ACCESS_CYC - 1);

    always_comb begin
        case (ph)
            PH_SETUP: len_m1 = SETUP_M1;
            PH_WTURN: len_m1 = TURN_M1;
            PH_WDATA: len_m1 = DATA_M1;
            PH_WHOLD: len_m1 = HOLD_M1;
            PH_RACC:  len_m1 = ACCESS_M1;
            default:  len_m1 = '0;
        endcase
    end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int TURN_CYC   = 2,
    parameter int DATA_CYC   = 4,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cap_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);

    seq_t                seq_d, seq_q;
    logic [ADDR_W-1:0]   addr_d, addr_q;
    logic [DATA_W-1:0]   wdata_d, wdata_q;
    phase_e              nxt_ph;
    logic [PH_CNT_W-1:0] nxt_len_m1;
    logic                accept;
    logic                last;

    assign req_ready = rst_n && (seq_q.ph == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign last      = (seq_q.cnt == '0);
    assign cap_en    = (seq_q.ph == PH_RACC) && last;

    // Phase transition; kept apart so the length lookup sees a settled value.
    always_comb begin
        nxt_ph = seq_q.ph;
        case (seq_q.ph)
            PH_IDLE:  if (accept) nxt_ph = PH_SETUP;
            PH_SETUP: if (last)   nxt_ph = seq_q.wr ? PH_WTURN : PH_RACC;
            PH_WTURN: if (last)   nxt_ph = PH_WDATA;
            PH_WDATA: if (last)   nxt_ph = PH_WHOLD;
            PH_WHOLD: if (last)   nxt_ph = PH_IDLE;
            PH_RACC:  if (last)   nxt_ph = PH_IDLE;
            default:              nxt_ph = PH_IDLE;
        endcase
    end

    asram_phase_len #(
        .SETUP_CYC  (SETUP_CYC),
        .TURN_CYC   (TURN_CYC),
        .DATA_CYC   (DATA_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .ACCESS_CYC (ACCESS_CYC)
    ) i_len (
        .ph     (nxt_ph),
        .len_m1 (nxt_len_m1)
    );

    always_comb begin
        seq_d   = seq_q;
        addr_d  = addr_q;
        wdata_d = wdata_q;

        if (accept) begin
            seq_d.wr = req_write;
            addr_d   = req_addr;
            wdata_d  = req_wdata;
        end

        seq_d.ph = nxt_ph;
        if (nxt_ph != seq_q.ph) begin
            seq_d.cnt = nxt_len_m1;
        end else if (!last) begin
            seq_d.cnt = seq_q.cnt - 1'b1;
        end

        seq_d.cs_act = (nxt_ph != PH_IDLE);
        seq_d.we_act = (nxt_ph == PH_WTURN) || (nxt_ph == PH_WDATA);
        seq_d.oe_act = (nxt_ph == PH_RACC);
        seq_d.drv    = (nxt_ph == PH_WDATA) || (nxt_ph == PH_WHOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q   <= '{ph: PH_IDLE, default: '0};
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            seq_q   <= seq_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_cs_n  = ~seq_q.cs_act;
    assign mem_cs    = seq_q.cs_act;
    assign mem_oe_n  = ~seq_q.oe_act;
    assign mem_we_n  = ~seq_q.we_act;
    assign mem_dq_o  = wdata_q;
    assign mem_dq_oe = seq_q.drv;

    // R10: read and write strobes are exclusive.
    a_r10_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_n == 1'b0 && mem_oe_n == 1'b0));

    // R10: the controller never drives while the RAM may be driving.
    a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R4: the bus is still released when write enable falls.
    a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);

    // R5: data and select persist across the edge that ends the write.
    a_r5_hold_over_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n && mem_cs));

    // R9: address is stable while selected.
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R2: an accepted request makes the controller busy on the next clock.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: a new setup is always preceded by a deselected clock.
    a_r8_gap_before_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> $past(mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic              valid_d, valid_q;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        valid_d = cap_en;
        rdata_d = cap_en ? dq_i : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            valid_q <= valid_d;
            rdata_q <= rdata_d;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_rdata = rdata_q;

    // R7: the response is a single-clock pulse.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7: capture happens while output enable is still asserted.
    a_r7_capture_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!oe_n));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int TURN_CYC   = 2,
    parameter int DATA_CYC   = 4,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    logic cap_en;

    asram_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SETUP_CYC  (SETUP_CYC),
        .TURN_CYC   (TURN_CYC),
        .DATA_CYC   (DATA_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .ACCESS_CYC (ACCESS_CYC)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cap_en    (cap_en),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_cs    (mem_cs),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe)
    );

    asram_rd_capture #(
        .DATA_W (DATA_W)
    ) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .oe_n      (mem_oe_n),
        .dq_i      (mem_dq_i),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;

    localparam int SU = 1, TU = 2, DA = 4, HO = 1, AC = 7;
    localparam int WR_LEN = SU + TU + DA + HO + 1;
    localparam int RD_LEN = SU + AC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o, mem_dq_i;

    int checks = 0;
    int errors = 0;
    int viol = 0;
    logic [7:0] model [int];
    logic       we_prev = 1'b1;
    logic        nxt_write;
    logic [16:0] nxt_addr;
    logic [7:0]  nxt_wdata;

    always #2.5 clk = ~clk;

    asram_ctrl #(
        .SETUP_CYC(SU), .TURN_CYC(TU), .DATA_CYC(DA), .HOLD_CYC(HO), .ACCESS_CYC(AC)
    ) i_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // RAM model: drives stored byte only when selected, reading, output enabled.
    wire sel = !mem_cs_n && mem_cs;
    assign mem_dq_i = (sel && !mem_oe_n && mem_we_n)
                      ? (model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'h00)
                      : 8'hC3;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_prev && mem_we_n && sel)
                model[int'(mem_addr)] = mem_dq_oe ? mem_dq_o : ~mem_dq_o;
            if ((!mem_we_n && !mem_oe_n) || (mem_dq_oe && !mem_oe_n)) viol++;
        end
        we_prev = mem_we_n;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ctl();
        return {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid};
    endfunction

    task automatic issue(input logic wr, input logic [16:0] a, input logic [7:0] d);
        if (!req_valid) begin
            @(negedge clk);
            req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        end
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic load_next(input bit keep);
        if (keep) begin
            req_write = nxt_write; req_addr = nxt_addr; req_wdata = nxt_wdata;
        end else begin
            req_valid = 1'b0;
        end
    endtask

    task automatic t_reset();
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00123; req_wdata = 8'h77;
        repeat (3) begin
            @(negedge clk);
            chk(ctl() == 7'b1011000, "R1 reset outputs", ctl(), 7'b1011000);
        end
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(ctl() == 7'b1011010, "R1 idle after reset", ctl(), 7'b1011010);
        end
    endtask

    task automatic t_write(input logic [16:0] a, input logic [7:0] d, input bit keep);
        logic [6:0] e;
        issue(1'b1, a, d);
        for (int k = 1; k <= WR_LEN; k++) begin
            @(negedge clk);
            if (k == 1) load_next(keep);
            if (k <= SU)                e = 7'b0111000;   // R3 setup
            else if (k <= SU + TU)      e = 7'b0101000;   // R4 turnaround
            else if (k <= SU + TU + DA) e = 7'b0101100;   // R5 data
            else if (k < WR_LEN)        e = 7'b0111100;   // R5 hold
            else                        e = 7'b1011010;   // R8 gap, R2 ready
            chk(ctl() == e, $sformatf("R3/R4/R5/R8 write clock %0d", k), ctl(), e);
            if (k < WR_LEN) chk(mem_addr == a, "R9 write address", mem_addr, a);
            if (k > SU + TU && k < WR_LEN) chk(mem_dq_o == d, "R5 write data", mem_dq_o, d);
        end
    endtask

    task automatic t_read(input logic [16:0] a, input logic [7:0] exp, input bit keep);
        logic [6:0] e;
        issue(1'b0, a, 8'h00);
        for (int k = 1; k <= RD_LEN; k++) begin
            @(negedge clk);
            if (k == 1) load_next(keep);
            if (k <= SU)          e = 7'b0111000;   // R3 setup
            else if (k < RD_LEN)  e = 7'b0110000;   // R6 access
            else                  e = 7'b1011011;   // R7 response, R8 gap
            chk(ctl() == e, $sformatf("R3/R6/R7 read clock %0d", k), ctl(), e);
            if (k < RD_LEN) chk(mem_addr == a, "R9 read address", mem_addr, a);
        end
        chk(rsp_rdata == exp, "R7 read data", rsp_rdata, exp);
    endtask

    task automatic t_basic();
        t_write(17'h00000, 8'hA5, 1'b0);
        t_write(17'h1FFFF, 8'h5A, 1'b0);
        t_write(17'h12345, 8'hFF, 1'b0);
        t_write(17'h0AAAA, 8'h00, 1'b0);
        t_read(17'h00000, 8'hA5, 1'b0);
        t_read(17'h1FFFF, 8'h5A, 1'b0);
        t_read(17'h12345, 8'hFF, 1'b0);
        t_read(17'h0AAAA, 8'h00, 1'b0);
    endtask

    task automatic t_back_to_back();
        nxt_write = 1'b0; nxt_addr = 17'h00777; nxt_wdata = 8'h00;
        t_write(17'h00777, 8'h3C, 1'b1);            // R8 valid held across
        nxt_write = 1'b0; nxt_addr = 17'h1FFFF; nxt_wdata = 8'h00;
        t_read(17'h00777, 8'h3C, 1'b1);
        t_read(17'h1FFFF, 8'h5A, 1'b0);
    endtask

    task automatic t_overwrite();
        t_write(17'h00000, 8'h81, 1'b0);
        t_read(17'h00000, 8'h81, 1'b0);
        t_read(17'h12345, 8'hFF, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_back_to_back();
        t_overwrite();
        @(negedge clk);
        chk(viol == 0, "R10 strobe/driver conflicts", viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule